// File: doc/BRIEF.md
# Serial Bus Pause Gate

This block sits between the pins of a serial peripheral bus and a slave engine that shifts bits in on rising clock edges and out on falling clock edges. It lets a host suspend a transfer without losing the transfer. The host pulls the active-low pause pin while the bus clock is low. From then on, clock and data movement on the pins is hidden from the engine, so the engine's bit count and shift register keep their contents, and the engine's data output is masked off so that the output pin can float. When the pause pin is released with the bus clock low, the engine sees the next clock edge as if nothing had happened.

All four pin inputs pass through a synchroniser into the system clock domain, and every decision is made on the synchronised levels. The block presents the engine with single-cycle strobes for qualified rising and falling edges of the bus clock, a qualified data bit, and an output-enable mask. A pause request that arrives while the bus clock is high is held back until the clock is low. Deselecting the block always clears the pause.

Top module: `spi_pause_gate`

## Requirements
- R1: While selected (cs_n low) and not paused, every rising bus-clock edge gives exactly one single-cycle pulse on sck_rise, and si_q equals the SI level in that cycle.
- R2: While selected and not paused, every falling bus-clock edge gives exactly one single-cycle pulse on sck_fall. This includes a falling edge that coincides with a pause entry that was held back.
- R3: When hold_n is low and sck is low while selected, paused goes to 1.
- R4: While paused, no pulse appears on sck_rise or sck_fall, whatever sck and SI do, and si_q keeps the value it had when the pause started.
- R5: so_en is 1 exactly when the block is selected and not paused. It is 0 while deselected and 0 while paused.
- R6: If hold_n falls while sck is high, paused stays 0 until sck goes low, and then becomes 1.
- R7: If hold_n rises while sck is high during a pause, paused stays 1 until sck goes low, and then clears. The falling edge at that moment gives no sck_fall pulse.
- R8: cs_n going high clears paused, and the next selection starts unpaused.
- R9: hold_n has no effect while deselected: paused stays 0 with cs_n high. With hold_n held high, the gate passes every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Bus select pin, active low |
| sck | input | 1 | Bus clock pin |
| si | input | 1 | Bus serial data in pin |
| hold_n | input | 1 | Pause request pin, active low |
| sck_rise | output | 1 | Qualified rising bus-clock edge strobe to the engine |
| sck_fall | output | 1 | Qualified falling bus-clock edge strobe to the engine |
| si_q | output | 1 | Qualified serial data bit to the engine |
| so_en | output | 1 | Output-enable mask for the engine's data output |
| paused | output | 1 | Pause state flag, for observation |

## Verification
The hardest cases to reach are the two held-back transitions. Each needs the pause pin to move while the bus clock is high, and the second one also needs the bus clock to rise while already paused. The stimulus builds this explicitly. It pauses with the clock low, raises the clock during the pause, releases the pause pin with the clock still high, and only then lowers the clock. For entry, it lowers the pause pin in the middle of a high clock phase. A scoreboard queue holds the bit expected at every edge that should pass. Any strobe leaking out during a pause therefore shows up either as an unexpected pop or as a count mismatch.

// File: rtl/spi_pause_gate_pkg.sv
// Package: shared pin bundle type and its idle value for the pause gate.
// Assumes pins are sampled together as one bundle by the synchroniser.
package spi_pause_gate_pkg;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
    } pins_t;

    localparam int PIN_COUNT = $bits(pins_t);

    // Idle bus: deselected, clock low, data low, no pause request.
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/pin_sync.sv
// Module: multi-stage level synchroniser for a bundle of asynchronous pins.
// Assumes each pin is a slow level relative to clk; no bus coherency is implied.
module pin_sync #(
    parameter int             WIDTH     = 4,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RESET_VAL;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                // Move the sample one stage further along.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= RESET_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clk_edge_gate.sv
// Module: detects bus-clock edges on the synchronised level and gates the
// strobes with a block signal. Assumes sck_s is already synchronous to clk.
module clk_edge_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic block,
    output logic rise,
    output logic fall
);
    logic sck_d;

    // Remember the previous clock level; it always tracks, even when blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise = sck_s & ~sck_d & ~block;
    assign fall = ~sck_s & sck_d & ~block;
endmodule

// File: rtl/pause_ctrl.sv
// Module: pause state machine. Enters and leaves pause only while the bus
// clock is low; selection loss clears it. Assumes synchronised inputs.
module pause_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic paused
);
    logic paused_nx;

    // Next pause state from the synchronised pin levels.
    always_comb begin
        paused_nx = paused;
        if (cs_n_s)                          paused_nx = 1'b0;
        else if (!paused && !hold_n_s && !sck_s) paused_nx = 1'b1;
        else if (paused && hold_n_s && !sck_s)   paused_nx = 1'b0;
    end

    // Pause state register.
    always_ff @(posedge clk) begin
        if (!rst_n) paused <= 1'b0;
        else        paused <= paused_nx;
    end

    // R3 / R6: a pause only begins after a cycle with the clock low.
    a_r3_enter_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(!sck_s && !cs_n_s && !hold_n_s));
    // R7: a pause ends only with the clock low or on deselect.
    a_r7_exit_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> $past(cs_n_s || (!sck_s && hold_n_s)));
    // R8: deselect clears the pause.
    a_r8_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !paused);
    // R9: no pause starts while the request is inactive.
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!paused && hold_n_s) |=> !paused);
endmodule

// File: rtl/spi_pause_gate.sv
// Module: top of the pause gate. Synchronises the pins, runs the pause state
// machine, qualifies clock edges and data, and masks the output enable.
// Assumes the engine drives its data output only while so_en is high.
module spi_pause_gate
    import spi_pause_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_q,
    output logic so_en,
    output logic paused
);
    pins_t pins_raw, pins_s;
    logic  si_held;
    logic  block;

    assign pins_raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n};

    pin_sync #(
        .WIDTH    (PIN_COUNT),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    pause_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s.cs_n),
        .sck_s   (pins_s.sck),
        .hold_n_s(pins_s.hold_n),
        .paused  (paused)
    );

    assign block = paused | pins_s.cs_n;

    clk_edge_gate u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck_s(pins_s.sck),
        .block(block),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    // Hold the last data bit seen before a pause.
    always_ff @(posedge clk) begin
        if (!rst_n)       si_held <= 1'b0;
        else if (!paused) si_held <= pins_s.si;
    end

    assign si_q  = paused ? si_held : pins_s.si;
    assign so_en = ~pins_s.cs_n & ~paused;

    // R4: no strobes while paused.
    a_r4_quiet_paused: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !(sck_rise || sck_fall));
    // R4: qualified data frozen across a pause.
    a_r4_si_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> $stable(si_q));
    // R5: output released while paused.
    a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_en);
    // R1 / R2: strobes are mutually exclusive.
    a_r1_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sck_rise, sck_fall}) <= 1);
endmodule

// File: tb/spi_pause_gate_test.sv
module spi_pause_gate_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic sck_rise, sck_fall, si_q, so_en, paused;

    int tests = 0, fails = 0;
    int rise_cnt = 0, fall_cnt = 0, exp_rise = 0, exp_fall = 0;
    logic exp_q[$];
    logic done = 1'b0;

    always #5 clk = ~clk;

    spi_pause_gate uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_q(si_q), .so_en(so_en), .paused(paused)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drive one bus-clock pulse; push the expected bit when it should pass.
    task automatic pulse(input logic b, input logic expect_pass);
        si = b;
        wait_clk(4);
        sck = 1'b1;
        if (expect_pass) begin
            exp_q.push_back(b);
            exp_rise++;
            exp_fall++;
        end
        wait_clk(5);
        sck = 1'b0;
        wait_clk(5);
    endtask

    // Monitor: pop and compare on every qualified rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sck_rise) begin
                rise_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R4 unexpected rise strobe", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(si_q == e, "R1 si_q at rise", int'(si_q), int'(e));
                end
            end
            if (sck_fall) fall_cnt++;
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic frozen;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check(so_en == 0, "R5 reset so_en", so_en, 0);
        check(paused == 0, "R3 reset paused", paused, 0);
        check(rise_cnt == 0, "R1 reset no strobes", rise_cnt, 0);

        // R9: pause request while deselected does nothing
        hold_n = 1'b0;
        wait_clk(6);
        check(paused == 0, "R9 hold while deselected", paused, 0);
        hold_n = 1'b1;
        wait_clk(4);

        // R1/R2: plain byte, hold high
        cs_n = 1'b0;
        wait_clk(5);
        check(so_en == 1, "R5 selected so_en", so_en, 1);
        for (int i = 7; i >= 0; i--) pulse(logic'((8'hA6 >> i) & 1), 1'b1);
        check(rise_cnt == exp_rise, "R1 rise count byte", rise_cnt, exp_rise);
        check(fall_cnt == exp_fall, "R2 fall count byte", fall_cnt, exp_fall);

        // R3: pause with clock low
        pulse(1'b1, 1'b1);
        frozen = 1'b1;
        hold_n = 1'b0;
        wait_clk(5);
        check(paused == 1, "R3 enter pause", paused, 1);
        check(so_en == 0, "R5 so_en off paused", so_en, 0);

        // R4: edges hidden while paused
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        pulse(1'b1, 1'b0);
        si = 1'b0;
        wait_clk(4);
        check(rise_cnt == exp_rise, "R4 no rise paused", rise_cnt, exp_rise);
        check(fall_cnt == exp_fall, "R4 no fall paused", fall_cnt, exp_fall);
        check(si_q == frozen, "R4 si_q frozen", si_q, frozen);

        // resume with clock low
        hold_n = 1'b1;
        wait_clk(5);
        check(paused == 0, "R3 exit pause", paused, 0);
        check(so_en == 1, "R5 so_en restored", so_en, 1);
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b1);
        check(rise_cnt == exp_rise, "R1 rise count resume", rise_cnt, exp_rise);

        // R6: request while clock high is deferred
        si = 1'b1;
        wait_clk(4);
        sck = 1'b1;
        exp_q.push_back(1'b1);
        exp_rise++;
        wait_clk(5);
        hold_n = 1'b0;
        wait_clk(6);
        check(paused == 0, "R6 deferred entry", paused, 0);
        sck = 1'b0;
        exp_fall++;
        wait_clk(6);
        check(paused == 1, "R6 entry after clock low", paused, 1);
        check(fall_cnt == exp_fall, "R2 fall at deferred entry", fall_cnt, exp_fall);

        // R7: release while clock high is deferred
        si = 1'b0;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(5);
        hold_n = 1'b1;
        wait_clk(6);
        check(paused == 1, "R7 deferred exit", paused, 1);
        sck = 1'b0;
        wait_clk(6);
        check(paused == 0, "R7 exit after clock low", paused, 0);
        check(fall_cnt == exp_fall, "R7 no fall at exit", fall_cnt, exp_fall);
        check(rise_cnt == exp_rise, "R4 no rise in pause", rise_cnt, exp_rise);

        // R8: deselect clears pause
        hold_n = 1'b0;
        wait_clk(5);
        check(paused == 1, "R8 paused before deselect", paused, 1);
        cs_n = 1'b1;
        wait_clk(5);
        check(paused == 0, "R8 deselect clears", paused, 0);
        hold_n = 1'b1;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(5);
        check(paused == 0, "R8 new select unpaused", paused, 0);
        for (int i = 7; i >= 0; i--) pulse(logic'((8'h3C >> i) & 1), 1'b1);
        cs_n = 1'b1;
        wait_clk(6);
        check(rise_cnt == exp_rise, "R9 transparent rise count", rise_cnt, exp_rise);
        check(fall_cnt == exp_fall, "R2 final fall count", fall_cnt, exp_fall);
        check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);
        check(so_en == 0, "R5 deselected so_en", so_en, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule